// File: doc/BRIEF.md
# Power-up release sequencer

This block decides when the core logic of a fixed-function device leaves reset after power is applied. It also decides when the device reports that it is ready on an open-drain done pin. The mode is chosen by a static two-bit select. Immediate mode releases the core as soon as the power-on reset ends. Delayed mode holds the core in reset for a fixed interval, nominally 50 ms, counted in system clocks. Emulation mode acts as though an external configuration stream were arriving. It counts rising edges of a configuration clock while a start control is asserted, and it releases after a set number of them. No configuration data is stored.

While the device is not yet in user mode, the done pin is driven low and weak pull-ups on the user I/O are enabled. At release, three things happen on the same system clock edge and then stay that way until the next power-on reset: the core reset deasserts, the done pin goes high-impedance, and the pull-ups turn off. The configuration pins are asynchronous to the system clock, so they pass through a synchroniser before they are used.

Top module: `boot_release_ctrl`

## Requirements
- R1: While `por_n` is low, `core_rst_n` is 0, `cdone_oe` is 1, `cdone_drv` is 0 and `io_pullup_en` is 1.
- R2: With `mode_sel` = 2'b00 (immediate), the outputs are released at the first rising clock edge at which `por_n` is sampled high.
- R3: With `mode_sel` = 2'b01 (delayed), release happens exactly DELAY_CYCLES clock edges after the first edge at which `por_n` is sampled high.
- R4: With `mode_sel` = 2'b10 (emulation), release happens on the third system clock edge after the pin-level rising edge of `cfg_clk` that completes a run of CFG_CLOCKS rising edges seen while `cfg_start` is high.
- R5: In emulation mode, a low level on `cfg_start` discards the edges counted so far, and counting starts again from zero.
- R6: In emulation mode, rising edges of `cfg_clk` that occur while `cfg_start` is low are not counted.
- R7: `cfg_data` has no effect on when the release happens.
- R8: Once released, `core_rst_n` stays 1 and `cdone_oe` and `io_pullup_en` stay 0 until `por_n` goes low again. All three change on the same clock edge.
- R9: `mode_sel` is sampled only at the first edge with `por_n` high. Later changes have no effect.
- R10: In immediate and delayed modes, activity on `cfg_clk` and `cfg_start` does not change the release time.
- R11: `cdone_drv` is always 0. The done pin is only ever pulled low or left floating.
- R12: `mode_sel` = 2'b11 behaves exactly like immediate mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Raw power-on reset, active low, used synchronously |
| mode_sel | input | 2 | Start-up mode: 00 immediate, 01 delayed, 10 emulation, 11 immediate |
| cfg_clk | input | 1 | Emulated configuration clock, asynchronous |
| cfg_start | input | 1 | Emulated configuration start control, active high, asynchronous |
| cfg_data | input | 1 | Emulated serial configuration data, accepted but not used |
| core_rst_n | output | 1 | Core reset, active low |
| cdone_drv | output | 1 | Data bit of the open-drain done pin, always 0 |
| cdone_oe | output | 1 | Output enable of the done pin; 1 while the pin is pulled low |
| io_pullup_en | output | 1 | Enables the weak pull-ups on user I/O |

## Verification
The immediate modes are due one edge after power-on reset is first sampled high. The delayed mode is due DELAY_CYCLES edges after that first edge. In emulation mode the output follows a pin-level `cfg_clk` rise by three system edges: two synchroniser stages and one edge-detect stage. The reference model in the bench keeps a three-deep history of the pin samples. It reads the rise and the start level from that history at the same depth, and it updates its release flag on every rising edge. The outputs are compared with the model on every falling edge, half a period after the update. The targeted checks sample on the exact falling edge before and after the expected release, and pulses are driven on falling edges and held for two cycles, so no edge is ever missed.

// File: rtl/bre_pkg.sv
// Shared types for the power-up release sequencer.
// Assumes: a two-bit static mode select. The encoding 2'b11 is folded onto immediate mode.
package bre_pkg;

    typedef enum logic [1:0] {
        MODE_NOW     = 2'b00,
        MODE_DELAY   = 2'b01,
        MODE_EMU     = 2'b10,
        MODE_NOW_ALT = 2'b11
    } boot_mode_e;

    typedef enum logic [1:0] {
        ST_POR  = 2'b00,
        ST_HOLD = 2'b01,
        ST_EMU  = 2'b10,
        ST_USER = 2'b11
    } seq_state_e;

endpackage

// File: rtl/bre_sync.sv
// Multi-bit, multi-stage level synchroniser.
// What it does: each bit of d_in passes through STAGES flip-flops clocked by clk.
// Assumes: the bits are independent levels (no bus coherence needed) and STAGES >= 2.
module bre_sync #(
    parameter int WIDTH  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [STAGES-1:0][WIDTH-1:0] chain_q;

    // Purpose: shift the asynchronous levels one stage per clock, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], d_in};
        end
    end

    assign d_out = chain_q[STAGES-1];

endmodule

// File: rtl/bre_delay_timer.sv
// Hold-interval timer for delayed start-up.
// What it does: while run_i is high it counts system clocks, and it raises expired_o in the
// LIMIT-th cycle of the run. Dropping run_i clears the count.
// Assumes: LIMIT >= 1.
module bre_delay_timer #(
    parameter int LIMIT = 2_500_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic expired_o
);

    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    assign expired_o = run_i && (cnt_q == CW'(LIMIT - 1));

    // Purpose: advance the hold counter while running; clear it when idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            cnt_q <= '0;
        end else if (!expired_o) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/bre_cfg_counter.sv
// Configuration-stream length emulator.
// What it does: finds rising edges of the synchronised configuration clock and counts them
// while the synchronised start control is high. complete_o pulses on the edge that makes
// COUNT. A low start level or a low enable clears the count.
// Assumes: inputs already synchronised to clk; COUNT >= 1. A configuration clock that is
// high when reset ends counts as one rising edge.
module bre_cfg_counter #(
    parameter int COUNT = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable_i,
    input  logic cclk_s_i,
    input  logic start_s_i,
    output logic complete_o
);

    localparam int CW = (COUNT > 1) ? $clog2(COUNT) : 1;

    logic          cclk_prev_q;
    logic          rise;
    logic [CW-1:0] edges_q;

    assign rise       = cclk_s_i && !cclk_prev_q;
    assign complete_o = enable_i && start_s_i && rise && (edges_q == CW'(COUNT - 1));

    // Purpose: remember the last clock level, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cclk_prev_q <= 1'b0;
        end else begin
            cclk_prev_q <= cclk_s_i;
        end
    end

    // Purpose: count qualified edges; restart whenever start drops or counting is disabled.
    always_ff @(posedge clk) begin
        if (!rst_n || !enable_i || !start_s_i) begin
            edges_q <= '0;
        end else if (rise && !complete_o) begin
            edges_q <= edges_q + 1'b1;
        end
    end

endmodule

// File: rtl/boot_release_ctrl.sv
// Power-up release sequencer, top level.
// What it does: chooses one of three start-up policies when power-on reset ends. It holds the
// core in reset, pulls the done pin low and enables I/O pull-ups until that policy completes,
// then releases all three together, once per power cycle.
// Assumes: por_n is already synchronous to clk. The configuration pins are asynchronous and are
// synchronised here. mode_sel is static and is read once.
module boot_release_ctrl
    import bre_pkg::*;
#(
    parameter int DELAY_CYCLES = 2_500_000,
    parameter int CFG_CLOCKS   = 1_000_000,
    parameter int SYNC_STAGES  = 2
) (
    input  logic       clk,
    input  logic       por_n,
    input  logic [1:0] mode_sel,
    input  logic       cfg_clk,
    input  logic       cfg_start,
    input  logic       cfg_data,
    output logic       core_rst_n,
    output logic       cdone_drv,
    output logic       cdone_oe,
    output logic       io_pullup_en
);

    seq_state_e state_q;
    logic       done_q;
    logic [1:0] cfg_sync;
    logic       cfg_clk_s;
    logic       cfg_start_s;
    logic       hold_expired;
    logic       emu_complete;
    logic       cfg_data_unused;

    // The serial data is accepted so a driving host sees a normal load. Its value is never used.
    assign cfg_data_unused = cfg_data;

    bre_sync #(
        .WIDTH  (2),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk   (clk),
        .rst_n (por_n),
        .d_in  ({cfg_start, cfg_clk}),
        .d_out (cfg_sync)
    );

    assign cfg_clk_s   = cfg_sync[0];
    assign cfg_start_s = cfg_sync[1];

    bre_delay_timer #(
        .LIMIT (DELAY_CYCLES)
    ) u_hold (
        .clk       (clk),
        .rst_n     (por_n),
        .run_i     (state_q == ST_HOLD),
        .expired_o (hold_expired)
    );

    bre_cfg_counter #(
        .COUNT (CFG_CLOCKS)
    ) u_emu (
        .clk        (clk),
        .rst_n      (por_n),
        .enable_i   (state_q == ST_EMU),
        .cclk_s_i   (cfg_clk_s),
        .start_s_i  (cfg_start_s),
        .complete_o (emu_complete)
    );

    // Purpose: latch the mode at the end of reset and step to user mode when the policy completes.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            state_q <= ST_POR;
            done_q  <= 1'b0;
        end else begin
            case (state_q)
                ST_POR: begin
                    case (boot_mode_e'(mode_sel))
                        MODE_DELAY: state_q <= ST_HOLD;
                        MODE_EMU:   state_q <= ST_EMU;
                        default: begin
                            state_q <= ST_USER;
                            done_q  <= 1'b1;
                        end
                    endcase
                end
                ST_HOLD: begin
                    if (hold_expired) begin
                        state_q <= ST_USER;
                        done_q  <= 1'b1;
                    end
                end
                ST_EMU: begin
                    if (emu_complete) begin
                        state_q <= ST_USER;
                        done_q  <= 1'b1;
                    end
                end
                default: begin
                    state_q <= ST_USER;
                end
            endcase
        end
    end

    assign core_rst_n   = done_q;
    assign cdone_drv    = 1'b0;
    assign cdone_oe     = !done_q;
    assign io_pullup_en = !done_q;

endmodule

// File: rtl/bre_checker.sv
// Property checker for boot_release_ctrl, attached with bind.
// What it does: checks release timing, stickiness and mode freezing against the ports and the
// sequencer state. A local counter measures the delayed-mode window.
// Assumes: por_n is the synchronous active-low reset of the checked block.
module bre_checker
    import bre_pkg::*;
#(
    parameter int DELAY_CYCLES = 2_500_000
) (
    input logic       clk,
    input logic       por_n,
    input logic [1:0] mode_sel,
    input logic       core_rst_n,
    input logic       cdone_oe,
    input seq_state_e state_q,
    input logic       cfg_start_s
);

    localparam int SAT = DELAY_CYCLES + 1;
    localparam int CW  = $clog2(SAT + 1);

    logic [CW-1:0] since_por_q;

    // Purpose: count edges since reset ended, saturating just past the hold window.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            since_por_q <= '0;
        end else if (since_por_q != CW'(SAT)) begin
            since_por_q <= since_por_q + 1'b1;
        end
    end

    AST_IMMEDIATE_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_POR) && ((mode_sel == 2'b00) || (mode_sel == 2'b11)) |=> core_rst_n); // R2

    AST_HOLD_EXACT: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_rst_n) && ($past(state_q) == ST_HOLD) |-> (since_por_q == CW'(SAT))); // R3

    AST_EMU_NEEDS_START: assert property (@(posedge clk) disable iff (!por_n)
        $rose(core_rst_n) && ($past(state_q) == ST_EMU) |-> $past(cfg_start_s)); // R4

    AST_CORE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        core_rst_n |=> core_rst_n); // R8

    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        !cdone_oe |=> !cdone_oe); // R8

    AST_HOLD_NO_SWITCH: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_HOLD) |=> (state_q == ST_HOLD) || (state_q == ST_USER)); // R9

    AST_EMU_NO_SWITCH: assert property (@(posedge clk) disable iff (!por_n)
        (state_q == ST_EMU) |=> (state_q == ST_EMU) || (state_q == ST_USER)); // R9

endmodule

bind boot_release_ctrl bre_checker #(
    .DELAY_CYCLES (DELAY_CYCLES)
) u_bre_checker (
    .clk         (clk),
    .por_n       (por_n),
    .mode_sel    (mode_sel),
    .core_rst_n  (core_rst_n),
    .cdone_oe    (cdone_oe),
    .state_q     (state_q),
    .cfg_start_s (cfg_start_s)
);

// File: tb/test_boot_release_ctrl.sv
// Bench for boot_release_ctrl: a behavioural reference model compared on every falling edge,
// plus targeted checks around each release point.
module test_boot_release_ctrl;

    localparam int DLY  = 40;
    localparam int CFGN = 12;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [1:0] mode_sel = 2'b00;
    logic       cfg_clk = 1'b0;
    logic       cfg_start = 1'b0;
    logic       cfg_data = 1'b0;
    logic       core_rst_n;
    logic       cdone_drv;
    logic       cdone_oe;
    logic       io_pullup_en;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    cmp_on = 1'b0;
    bit    wiggle = 1'b0;
    string cur_req = "R1";

    // Reference model state
    int       m_phase = 0;
    bit       m_done = 1'b0;
    int       m_hold = 0;
    int       m_ec = 0;
    bit [1:0] m_mode = 2'b00;
    bit       hc [3] = '{1'b0, 1'b0, 1'b0};
    bit       hs [3] = '{1'b0, 1'b0, 1'b0};

    always #10 clk = ~clk;

    boot_release_ctrl #(
        .DELAY_CYCLES (DLY),
        .CFG_CLOCKS   (CFGN),
        .SYNC_STAGES  (2)
    ) i_boot_release_ctrl (
        .clk          (clk),
        .por_n        (por_n),
        .mode_sel     (mode_sel),
        .cfg_clk      (cfg_clk),
        .cfg_start    (cfg_start),
        .cfg_data     (cfg_data),
        .core_rst_n   (core_rst_n),
        .cdone_drv    (cdone_drv),
        .cdone_oe     (cdone_oe),
        .io_pullup_en (io_pullup_en)
    );

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // Behavioural model: the pin history is read two edges deep, and release is decided per policy.
    always @(posedge clk) begin
        bit rise;
        bit st;
        if (!por_n) begin
            m_phase = 0;
            m_done  = 1'b0;
            hc = '{1'b0, 1'b0, 1'b0};
            hs = '{1'b0, 1'b0, 1'b0};
        end else begin
            rise = hc[1] && !hc[2];
            st   = hs[1];
            if (m_phase == 0) begin
                m_mode  = mode_sel;
                m_phase = 1;
                m_hold  = 0;
                m_ec    = 0;
                if (mode_sel == 2'b00 || mode_sel == 2'b11) m_done = 1'b1;
            end else if (!m_done) begin
                if (m_mode == 2'b01) begin
                    m_hold++;
                    if (m_hold == DLY) m_done = 1'b1;
                end else if (m_mode == 2'b10) begin
                    if (!st) m_ec = 0;
                    else if (rise) begin
                        m_ec++;
                        if (m_ec == CFGN) m_done = 1'b1;
                    end
                end
            end
            hc[2] = hc[1]; hc[1] = hc[0]; hc[0] = cfg_clk;
            hs[2] = hs[1]; hs[1] = hs[0]; hs[0] = cfg_start;
        end
    end

    // Per-cycle comparison of all four outputs against the model (R11 included via cdone_drv).
    always @(negedge clk) begin
        if (cmp_on) begin
            check((core_rst_n === m_done) && (cdone_oe === !m_done) &&
                  (io_pullup_en === !m_done) && (cdone_drv === 1'b0),
                  cur_req, "outputs {rst,oe,pu,drv}",
                  int'({core_rst_n, cdone_oe, io_pullup_en, cdone_drv}),
                  int'({m_done, !m_done, !m_done, 1'b0}));
        end
    end

    // Power-on reset with the given mode; checks the reset state (R1).
    task automatic por_cycle(input logic [1:0] m);
        por_n = 1'b0; mode_sel = m; cfg_clk = 1'b0; cfg_start = 1'b0; cfg_data = 1'b0;
        @(negedge clk);
        cmp_on = 1'b1;
        repeat (2) @(negedge clk);
        check(core_rst_n == 1'b0 && cdone_oe == 1'b1 && io_pullup_en == 1'b1 && cdone_drv == 1'b0,
              "R1", "reset state {rst,oe,pu,drv}",
              int'({core_rst_n, cdone_oe, io_pullup_en, cdone_drv}), 6);
        por_n = 1'b1;
    endtask

    task automatic cfg_pulse();
        cfg_clk = 1'b1;
        repeat (2) begin @(negedge clk); if (wiggle) cfg_data = ~cfg_data; end
        cfg_clk = 1'b0;
        repeat (2) begin @(negedge clk); if (wiggle) cfg_data = ~cfg_data; end
    endtask

    task automatic cycles_to_release(output int n);
        n = 0;
        while (!core_rst_n && n < 1000) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: got %0d expected %0d", 1, 0);
        summary();
    end

    initial begin
        int n_a;
        int n_b;

        // R2 immediate; R9 mode change afterwards
        cur_req = "R2";
        por_cycle(2'b00);
        @(negedge clk);
        check(core_rst_n == 1'b1, "R2", "core_rst_n one edge after reset", core_rst_n, 1);
        mode_sel = 2'b01;
        cur_req = "R9";
        repeat (5) @(negedge clk);
        check(core_rst_n == 1'b1 && cdone_oe == 1'b0, "R9", "still released after mode change", core_rst_n, 1);

        // R12 alternate immediate encoding
        cur_req = "R12";
        por_cycle(2'b11);
        @(negedge clk);
        check(core_rst_n == 1'b1, "R12", "mode 11 releases like immediate", core_rst_n, 1);
        repeat (3) @(negedge clk);

        // R3 delayed, with R10 configuration activity and R9 mode change
        cur_req = "R3";
        por_cycle(2'b01);
        cfg_start = 1'b1;
        for (int i = 1; i <= DLY + 1; i++) begin
            @(negedge clk);
            if (i == 2) mode_sel = 2'b00;
            cfg_clk = i[1];
            if (i == 3) check(core_rst_n == 1'b0, "R9", "mode change ignored in hold", core_rst_n, 0);
            if (i == DLY) check(core_rst_n == 1'b0, "R3", "held on last hold cycle", core_rst_n, 0);
            if (i == DLY) check(cdone_oe == 1'b1, "R10", "cfg activity did not shorten hold", cdone_oe, 1);
            if (i == DLY + 1) check(core_rst_n == 1'b1 && io_pullup_en == 1'b0, "R3", "released after hold", core_rst_n, 1);
        end
        cfg_clk = 1'b0;
        repeat (4) @(negedge clk);

        // R4 emulation, plain
        cur_req = "R4";
        por_cycle(2'b10);
        cfg_start = 1'b1;
        @(negedge clk);
        for (int p = 0; p < CFGN - 1; p++) cfg_pulse();
        check(core_rst_n == 1'b0, "R4", "held one edge short", core_rst_n, 0);
        cfg_pulse();
        check(core_rst_n == 1'b1 && cdone_oe == 1'b0, "R4", "released after full count", core_rst_n, 1);

        // R8 sticky release under later configuration activity
        cur_req = "R8";
        cfg_start = 1'b0;
        cfg_pulse();
        cfg_start = 1'b1;
        cfg_pulse();
        check(core_rst_n == 1'b1 && cdone_oe == 1'b0 && io_pullup_en == 1'b0, "R8", "release is sticky",
              int'({core_rst_n, cdone_oe, io_pullup_en}), 4);

        // R5 restart on start deassertion
        cur_req = "R5";
        por_cycle(2'b10);
        cfg_start = 1'b1;
        @(negedge clk);
        for (int p = 0; p < 7; p++) cfg_pulse();
        cfg_start = 1'b0;
        repeat (3) @(negedge clk);
        cfg_start = 1'b1;
        repeat (2) @(negedge clk);
        for (int p = 0; p < CFGN - 1; p++) cfg_pulse();
        check(core_rst_n == 1'b0, "R5", "count restarted after start dropped", core_rst_n, 0);
        cfg_pulse();
        check(core_rst_n == 1'b1, "R5", "released after fresh full count", core_rst_n, 1);

        // R6 edges while start low are not counted
        cur_req = "R6";
        por_cycle(2'b10);
        @(negedge clk);
        for (int p = 0; p < 5; p++) cfg_pulse();
        cfg_start = 1'b1;
        repeat (2) @(negedge clk);
        for (int p = 0; p < CFGN - 1; p++) cfg_pulse();
        check(core_rst_n == 1'b0, "R6", "edges with start low ignored", core_rst_n, 0);
        cfg_pulse();
        check(core_rst_n == 1'b1, "R6", "released after counted edges", core_rst_n, 1);

        // R7 serial data does not change the release time
        cur_req = "R7";
        wiggle = 1'b0;
        por_cycle(2'b10);
        cfg_start = 1'b1;
        for (int p = 0; p < CFGN - 1; p++) cfg_pulse();
        cfg_clk = 1'b1;
        cycles_to_release(n_a);
        cfg_clk = 1'b0;
        wiggle = 1'b1;
        por_cycle(2'b10);
        cfg_start = 1'b1;
        cfg_data = 1'b1;
        for (int p = 0; p < CFGN - 1; p++) cfg_pulse();
        cfg_clk = 1'b1;
        cycles_to_release(n_b);
        cfg_clk = 1'b0;
        wiggle = 1'b0;
        check(n_a == n_b, "R7", "release delay with toggling data", n_b, n_a);
        check(n_a == 3, "R4", "edges from last pin rise to release", n_a, 3);
        repeat (4) @(negedge clk);

        cmp_on = 1'b0;
        summary();
    end

endmodule